// File: doc/BRIEF.md
# Pseudo-Random Memory Traffic Engine

The engine creates scattered, full-width memory traffic for bandwidth tests. A job starts with a single `start` pulse, which carries a word count and a repeat count. The engine then fetches pairs of 1024-bit words, one from each of two read masters. The addresses are scattered by free-running shift-register generators. For each pair, the engine writes the lane-wise sum through one write master and the lane-wise product through the other. These writes also go to scattered addresses.

Each read master has a credit counter, so many requests can wait on a slow memory at the same time. Each credit reserves a slot in a local response buffer, so a response is never refused. The heads of the two buffers leave together, which keeps input pairs in issue order. A job is complete only when every write response for every pair has come back. A one-cycle `done` pulse then marks the end of the job.

Top module: `prt_traffic_engine`

## Requirements
- R1: For the k-th input pair, the word on the sum port holds, in every 32-bit lane i (bits 32i+31..32i), the sum of the two input lanes modulo 2^32.
- R2: For the same pair, the word on the product port holds, in every lane, the low 32 bits of the unsigned product of the two input lanes.
- R3: Each of the four ports has its own 16-bit generator. The seeds are 0xACE1 for read A, 0x5EED for read B, 0xBEEF for sum and 0x1234 for product. The generators are reloaded on every accepted `start`. A port's generator advances only when that port's request is accepted, by the step s -> (s >> 1) XOR (s[0] ? 0xB400 : 0). It carries on across repeats without reloading. The request address is floor(s * size / 65536).
- R4: Every request address is below the size latched at `start`.
- R5: The k-th sum write and the k-th product write are both built from the k-th response of read A and the k-th response of read B.
- R6: On each read port, accepted requests minus accepted responses never exceeds MAX_OUT (64 by default). The response ready is never low while that port is still waiting for a response.
- R7: Within one job, each of the four ports accepts exactly size × repeats requests.
- R8: `done` is high for exactly the one cycle that follows the clock edge where the last outstanding write response is accepted.
- R9: If the size or the repeat count is zero, `done` is high in the cycle after `start` and no request is raised.
- R10: A `start` pulse that arrives while a job is running has no effect on that job's addresses, data or counts.
- R11: A request held back by a low ready keeps its valid high, and its address and data unchanged, until it is accepted.
- R12: After reset, `done` and every request valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a job (used only while idle) |
| size_words | input | 32 | Words per pass, latched at start |
| repeat_cnt | input | 32 | Number of passes, latched at start |
| done | output | 1 | One-cycle job completion pulse |
| ra_req_valid | output | 1 | Read A request valid |
| ra_req_ready | input | 1 | Read A request ready |
| ra_req_addr | output | 32 | Read A word address |
| ra_rsp_valid | input | 1 | Read A response valid |
| ra_rsp_ready | output | 1 | Read A response ready |
| ra_rsp_data | input | LANES*32 | Read A response word |
| rb_req_valid | output | 1 | Read B request valid |
| rb_req_ready | input | 1 | Read B request ready |
| rb_req_addr | output | 32 | Read B word address |
| rb_rsp_valid | input | 1 | Read B response valid |
| rb_rsp_ready | output | 1 | Read B response ready |
| rb_rsp_data | input | LANES*32 | Read B response word |
| ws_req_valid | output | 1 | Sum write request valid |
| ws_req_ready | input | 1 | Sum write request ready |
| ws_req_addr | output | 32 | Sum write word address |
| ws_req_data | output | LANES*32 | Sum write word |
| ws_rsp_valid | input | 1 | Sum write response valid |
| ws_rsp_ready | output | 1 | Sum write response ready |
| wp_req_valid | output | 1 | Product write request valid |
| wp_req_ready | input | 1 | Product write request ready |
| wp_req_addr | output | 32 | Product write word address |
| wp_req_data | output | LANES*32 | Product write word |
| wp_rsp_valid | input | 1 | Product write response valid |
| wp_rsp_ready | output | 1 | Product write response ready |

## Verification
The hardest state to reach is a read port whose credit window is full. The request has to be stalled by the credit rule and not by a low ready. Meanwhile responses and buffer pops free credits in the same cycles that new requests are accepted. The bench reaches this state with a long-latency mode: each read responds about forty cycles after it is accepted, and request ready is held high. This lets the window fill to its limit before any response returns. A second mode uses short random latencies and random ready on all four ports. That mode stresses pairing order and the holding of stalled requests, and it injects a `start` pulse into the middle of one job.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int CNT_W  = 32;
    localparam int LANE_W = 32;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic [0:0] {PH_IDLE, PH_RUN} phase_e;

    typedef struct packed {
        logic [2*CNT_W-1:0] total;
        logic [CNT_W-1:0]   size;
    } job_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

    function automatic logic [LFSR_W-1:0] port_seed(input int idx);
        case (idx)
            0:       return 16'hACE1;
            1:       return 16'h5EED;
            2:       return 16'hBEEF;
            default: return 16'h1234;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] scale_addr(input logic [LFSR_W-1:0] s,
                                                   input logic [CNT_W-1:0] size);
        return CNT_W'((48'(s) * 48'(size)) >> LFSR_W);
    endfunction

    function automatic logic [LANE_W-1:0] lane_add(input logic [LANE_W-1:0] a,
                                                   input logic [LANE_W-1:0] b);
        return a + b;
    endfunction

    function automatic logic [LANE_W-1:0] lane_mul(input logic [LANE_W-1:0] a,
                                                   input logic [LANE_W-1:0] b);
        return a * b;
    endfunction

endpackage

// File: rtl/prt_lfsr_addr.sv
module prt_lfsr_addr
    import prt_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] size,
    output logic [CNT_W-1:0] addr
);

    logic [LFSR_W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst || load) st <= SEED;
        else if (step)   st <= lfsr_step(st);
    end

    assign addr = scale_addr(st, size);

    a_r3_state_nonzero: assert property (@(posedge clk) disable iff (rst)
        st != '0);

    a_r3_step_only_on_accept: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(st));

endmodule

// File: rtl/prt_fifo.sv
module prt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wrap_inc(wp);
            if (pop)  rp <= wrap_inc(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/prt_rd_port.sv
module prt_rd_port
    import prt_pkg::*;
#(
    parameter int                WORD_W  = 1024,
    parameter int                MAX_OUT = 64,
    parameter logic [LFSR_W-1:0] SEED    = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               active,
    input  logic [CNT_W-1:0]   size,
    input  logic [2*CNT_W-1:0] total,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [CNT_W-1:0]   req_addr,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [WORD_W-1:0]  rsp_data,
    input  logic               pop,
    output logic               head_ok,
    output logic [WORD_W-1:0]  head
);

    localparam int CW = $clog2(MAX_OUT+1);

    logic [CW-1:0]      outst;
    logic [CW-1:0]      fcount;
    logic [CW:0]        inflight;
    logic [2*CNT_W-1:0] issued;
    logic               ffull, fempty;
    logic               req_acc, rsp_acc;

    assign inflight  = {1'b0, outst} + {1'b0, fcount};
    assign req_valid = active && (issued != total)
                    && (outst < CW'(MAX_OUT))
                    && (inflight < (CW+1)'(MAX_OUT));
    assign req_acc   = req_valid && req_ready;
    assign rsp_ready = !ffull;
    assign rsp_acc   = rsp_valid && rsp_ready;
    assign head_ok   = !fempty;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            outst  <= '0;
            issued <= '0;
        end else begin
            if (req_acc) issued <= issued + 1'b1;
            case ({req_acc, rsp_acc})
                2'b10:   outst <= outst + 1'b1;
                2'b01:   outst <= outst - 1'b1;
                default: ;
            endcase
        end
    end

    prt_lfsr_addr #(.SEED(SEED)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (req_acc),
        .size (size),
        .addr (req_addr)
    );

    prt_fifo #(.W(WORD_W), .DEPTH(MAX_OUT)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (rsp_acc),
        .din   (rsp_data),
        .pop   (pop),
        .dout  (head),
        .count (fcount),
        .full  (ffull),
        .empty (fempty)
    );

    a_r6_outstanding_cap: assert property (@(posedge clk) disable iff (rst)
        outst <= CW'(MAX_OUT));

    a_r6_rsp_only_when_waiting: assert property (@(posedge clk) disable iff (rst)
        rsp_acc |-> (outst != '0));

    a_r6_ready_while_waiting: assert property (@(posedge clk) disable iff (rst)
        (outst != '0) |-> rsp_ready);

    a_r4_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr < size));

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    a_r7_issue_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (issued <= total));

endmodule

// File: rtl/prt_wr_port.sv
module prt_wr_port
    import prt_pkg::*;
#(
    parameter int                WORD_W = 1024,
    parameter logic [LFSR_W-1:0] SEED   = 16'hBEEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [CNT_W-1:0]   size,
    input  logic               set,
    input  logic [WORD_W-1:0]  din,
    output logic               pend,
    output logic               acc,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [CNT_W-1:0]   req_addr,
    output logic [WORD_W-1:0]  req_data,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    output logic               rsp_acc,
    output logic [2*CNT_W-1:0] rsp_cnt
);

    logic [WORD_W-1:0] data_q;

    assign req_valid = pend;
    assign req_data  = data_q;
    assign acc       = pend && req_ready;
    assign rsp_ready = 1'b1;
    assign rsp_acc   = rsp_valid;

    always_ff @(posedge clk) begin
        if (set) data_q <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pend    <= 1'b0;
            rsp_cnt <= '0;
        end else begin
            if (set)      pend <= 1'b1;
            else if (acc) pend <= 1'b0;
            if (rsp_acc)  rsp_cnt <= rsp_cnt + 1'b1;
        end
    end

    prt_lfsr_addr #(.SEED(SEED)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (acc),
        .size (size),
        .addr (req_addr)
    );

    a_r11_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_data)));

    a_r5_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        set |-> (!pend || acc));

endmodule

// File: rtl/prt_traffic_engine.sv
module prt_traffic_engine
    import prt_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int MAX_OUT = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [CNT_W-1:0]        size_words,
    input  logic [CNT_W-1:0]        repeat_cnt,
    output logic                    done,
    output logic                    ra_req_valid,
    input  logic                    ra_req_ready,
    output logic [CNT_W-1:0]        ra_req_addr,
    input  logic                    ra_rsp_valid,
    output logic                    ra_rsp_ready,
    input  logic [LANES*LANE_W-1:0] ra_rsp_data,
    output logic                    rb_req_valid,
    input  logic                    rb_req_ready,
    output logic [CNT_W-1:0]        rb_req_addr,
    input  logic                    rb_rsp_valid,
    output logic                    rb_rsp_ready,
    input  logic [LANES*LANE_W-1:0] rb_rsp_data,
    output logic                    ws_req_valid,
    input  logic                    ws_req_ready,
    output logic [CNT_W-1:0]        ws_req_addr,
    output logic [LANES*LANE_W-1:0] ws_req_data,
    input  logic                    ws_rsp_valid,
    output logic                    ws_rsp_ready,
    output logic                    wp_req_valid,
    input  logic                    wp_req_ready,
    output logic [CNT_W-1:0]        wp_req_addr,
    output logic [LANES*LANE_W-1:0] wp_req_data,
    input  logic                    wp_rsp_valid,
    output logic                    wp_rsp_ready
);

    localparam int WORD_W = LANES * LANE_W;
    localparam int TOT_W  = 2 * CNT_W;

    phase_e            phase;
    job_t              job;
    logic              done_q;
    logic              load, active, finish, pair_pop;
    logic [TOT_W-1:0]  req_total;

    logic [1:0]        rd_vld, rd_rdy, rs_vld, rs_rdy, head_ok;
    logic [CNT_W-1:0]  rd_addr [2];
    logic [WORD_W-1:0] rs_data [2];
    logic [WORD_W-1:0] head    [2];

    logic [1:0]        wr_pend, wr_acc, wr_vld, wr_rdy, wr_rsp_vld, wr_rsp_rdy, wr_rsp_acc;
    logic [CNT_W-1:0]  wr_addr    [2];
    logic [WORD_W-1:0] wr_data    [2];
    logic [WORD_W-1:0] res_w      [2];
    logic [TOT_W-1:0]  wr_rsp_cnt [2];
    logic [TOT_W-1:0]  cnt_nx     [2];

    assign load      = start && (phase == PH_IDLE);
    assign active    = (phase == PH_RUN);
    assign req_total = TOT_W'(size_words) * TOT_W'(repeat_cnt);
    assign done      = done_q;

    // port bundling
    assign rd_rdy     = {rb_req_ready, ra_req_ready};
    assign rs_vld     = {rb_rsp_valid, ra_rsp_valid};
    assign rs_data[0] = ra_rsp_data;
    assign rs_data[1] = rb_rsp_data;
    assign ra_req_valid = rd_vld[0];
    assign rb_req_valid = rd_vld[1];
    assign ra_req_addr  = rd_addr[0];
    assign rb_req_addr  = rd_addr[1];
    assign ra_rsp_ready = rs_rdy[0];
    assign rb_rsp_ready = rs_rdy[1];

    assign wr_rdy     = {wp_req_ready, ws_req_ready};
    assign wr_rsp_vld = {wp_rsp_valid, ws_rsp_valid};
    assign ws_req_valid = wr_vld[0];
    assign wp_req_valid = wr_vld[1];
    assign ws_req_addr  = wr_addr[0];
    assign wp_req_addr  = wr_addr[1];
    assign ws_req_data  = wr_data[0];
    assign wp_req_data  = wr_data[1];
    assign ws_rsp_ready = wr_rsp_rdy[0];
    assign wp_rsp_ready = wr_rsp_rdy[1];

    // read masters
    for (genvar g = 0; g < 2; g++) begin : g_rd
        prt_rd_port #(
            .WORD_W  (WORD_W),
            .MAX_OUT (MAX_OUT),
            .SEED    (port_seed(g))
        ) u_rd (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .active    (active),
            .size      (job.size),
            .total     (job.total),
            .req_valid (rd_vld[g]),
            .req_ready (rd_rdy[g]),
            .req_addr  (rd_addr[g]),
            .rsp_valid (rs_vld[g]),
            .rsp_ready (rs_rdy[g]),
            .rsp_data  (rs_data[g]),
            .pop       (pair_pop),
            .head_ok   (head_ok[g]),
            .head      (head[g])
        );
    end

    // lane datapath
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign res_w[0][l*LANE_W +: LANE_W] =
            lane_add(head[0][l*LANE_W +: LANE_W], head[1][l*LANE_W +: LANE_W]);
        assign res_w[1][l*LANE_W +: LANE_W] =
            lane_mul(head[0][l*LANE_W +: LANE_W], head[1][l*LANE_W +: LANE_W]);
    end

    assign pair_pop = active && head_ok[0] && head_ok[1]
                   && (!wr_pend[0] || wr_acc[0])
                   && (!wr_pend[1] || wr_acc[1]);

    // write masters
    for (genvar g = 0; g < 2; g++) begin : g_wr
        prt_wr_port #(
            .WORD_W (WORD_W),
            .SEED   (port_seed(g + 2))
        ) u_wr (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .size      (job.size),
            .set       (pair_pop),
            .din       (res_w[g]),
            .pend      (wr_pend[g]),
            .acc       (wr_acc[g]),
            .req_valid (wr_vld[g]),
            .req_ready (wr_rdy[g]),
            .req_addr  (wr_addr[g]),
            .req_data  (wr_data[g]),
            .rsp_valid (wr_rsp_vld[g]),
            .rsp_ready (wr_rsp_rdy[g]),
            .rsp_acc   (wr_rsp_acc[g]),
            .rsp_cnt   (wr_rsp_cnt[g])
        );
        assign cnt_nx[g] = wr_rsp_cnt[g] + TOT_W'(wr_rsp_acc[g]);
    end

    assign finish = active && (cnt_nx[0] == job.total) && (cnt_nx[1] == job.total);

    // job control
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            job    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                job.total <= req_total;
                job.size  <= size_words;
                if (req_total == '0) done_q <= 1'b1;
                else                 phase  <= PH_RUN;
            end else if (finish) begin
                phase  <= PH_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (rd_vld == 2'b00 && wr_vld == 2'b00));

    a_r7_rsp_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (wr_rsp_cnt[0] <= job.total && wr_rsp_cnt[1] <= job.total));

    a_r10_job_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && !finish) |=> $stable(job));

endmodule

// File: tb/test_prt_traffic_engine.sv
module test_prt_traffic_engine;

    localparam int LN = 4;
    localparam int MO = 8;
    localparam int WW = LN * 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          start = 1'b0;
    logic [31:0]   size_w = '0, rep_w = '0;
    logic          done;
    logic [1:0]    rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
    logic [31:0]   rd_req_addr [2];
    logic [WW-1:0] rd_rsp_data [2];
    logic [1:0]    wr_req_valid, wr_req_ready, wr_rsp_valid, wr_rsp_ready;
    logic [31:0]   wr_req_addr [2];
    logic [WW-1:0] wr_req_data [2];

    prt_traffic_engine #(.LANES(LN), .MAX_OUT(MO)) i_prt_traffic_engine (
        .clk(clk), .rst(rst), .start(start),
        .size_words(size_w), .repeat_cnt(rep_w), .done(done),
        .ra_req_valid(rd_req_valid[0]), .ra_req_ready(rd_req_ready[0]),
        .ra_req_addr(rd_req_addr[0]), .ra_rsp_valid(rd_rsp_valid[0]),
        .ra_rsp_ready(rd_rsp_ready[0]), .ra_rsp_data(rd_rsp_data[0]),
        .rb_req_valid(rd_req_valid[1]), .rb_req_ready(rd_req_ready[1]),
        .rb_req_addr(rd_req_addr[1]), .rb_rsp_valid(rd_rsp_valid[1]),
        .rb_rsp_ready(rd_rsp_ready[1]), .rb_rsp_data(rd_rsp_data[1]),
        .ws_req_valid(wr_req_valid[0]), .ws_req_ready(wr_req_ready[0]),
        .ws_req_addr(wr_req_addr[0]), .ws_req_data(wr_req_data[0]),
        .ws_rsp_valid(wr_rsp_valid[0]), .ws_rsp_ready(wr_rsp_ready[0]),
        .wp_req_valid(wr_req_valid[1]), .wp_req_ready(wr_req_ready[1]),
        .wp_req_addr(wr_req_addr[1]), .wp_req_data(wr_req_data[1]),
        .wp_rsp_valid(wr_rsp_valid[1]), .wp_rsp_ready(wr_rsp_ready[1])
    );

    int checks = 0;
    int fails  = 0;

    // model state
    bit          model_on = 1'b0;
    int          mode = 0;
    longint      cyc = 0;
    longint      done_exp = -1;
    bit          done_seen = 1'b0;
    int          done_cnt = 0;
    int unsigned cur_size = 0;
    int          cur_total = 0;
    logic [15:0] ms [4];
    int unsigned rq_addr [2][$];
    longint      rq_due  [2][$];
    int unsigned rd_hist [2][$];
    longint      wq_due  [2][$];
    int          rd_cnt [2], wr_cnt [2], wr_rsp_n [2], maxo [2];
    bit          hold_r [2], hold_w [2];
    logic [31:0] hold_ra [2], hold_wa [2];
    logic [WW-1:0] hold_wd [2];

    function automatic logic [15:0] bstep(input logic [15:0] s);
        if (s[0]) return (s >> 1) ^ 16'hB400;
        return s >> 1;
    endfunction

    function automatic logic [31:0] bscale(input logic [15:0] s, input int unsigned sz);
        longint unsigned p;
        p = longint'(s) * longint'(sz);
        return 32'(p >> 16);
    endfunction

    function automatic logic [31:0] memv(input int p, input int unsigned a, input int l);
        return 32'(a) * 32'h9E3779B1 + 32'(p) * 32'h7F4A7C15 + 32'(l + 1) * 32'h85EBCA6B;
    endfunction

    function automatic logic [WW-1:0] memword(input int p, input int unsigned a);
        logic [WW-1:0] w;
        for (int l = 0; l < LN; l++) w[l*32 +: 32] = memv(p, a, l);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // memory and response model, runs at every falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!model_on) begin
                rd_req_ready = '0; rd_rsp_valid = '0;
                wr_req_ready = '0; wr_rsp_valid = '0;
                rd_rsp_data[0] = '0; rd_rsp_data[1] = '0;
            end else begin
                if (done) begin
                    done_seen = 1'b1;
                    done_cnt++;
                    chk(cyc == done_exp, "R8", "done cycle", WW'(cyc), WW'(done_exp));
                end
                for (int p = 0; p < 2; p++) begin
                    bit rdy;
                    if (hold_r[p]) begin
                        chk(rd_req_valid[p] && rd_req_addr[p] == hold_ra[p], "R11",
                            "stalled read held", WW'(rd_req_addr[p]), WW'(hold_ra[p]));
                        hold_r[p] = 1'b0;
                    end
                    rdy = (mode == 1) ? 1'b1 : (($urandom % 4) != 0);
                    rd_req_ready[p] = rdy;
                    if (rd_req_valid[p]) begin
                        if (rdy) begin
                            logic [31:0] ea;
                            ea = bscale(ms[p], cur_size);
                            chk(rd_req_addr[p] == ea, "R3", "read address",
                                WW'(rd_req_addr[p]), WW'(ea));
                            chk(rd_req_addr[p] < cur_size, "R4", "read address range",
                                WW'(rd_req_addr[p]), WW'(cur_size));
                            ms[p] = bstep(ms[p]);
                            rq_addr[p].push_back(rd_req_addr[p]);
                            rq_due[p].push_back(cyc + ((mode == 1) ? 40 : 1 + ($urandom % 5)));
                            rd_hist[p].push_back(rd_req_addr[p]);
                            rd_cnt[p]++;
                        end else begin
                            hold_r[p]  = 1'b1;
                            hold_ra[p] = rd_req_addr[p];
                        end
                    end
                    if (rq_due[p].size() > 0 && rq_due[p][0] <= cyc) begin
                        rd_rsp_valid[p] = 1'b1;
                        rd_rsp_data[p]  = memword(p, rq_addr[p][0]);
                        if (rd_rsp_ready[p]) begin
                            void'(rq_addr[p].pop_front());
                            void'(rq_due[p].pop_front());
                        end
                    end else begin
                        rd_rsp_valid[p] = 1'b0;
                    end
                    if (rq_addr[p].size() > maxo[p]) maxo[p] = rq_addr[p].size();
                end
                for (int p = 0; p < 2; p++) begin
                    bit rdy;
                    if (hold_w[p]) begin
                        chk(wr_req_valid[p] && wr_req_addr[p] == hold_wa[p]
                            && wr_req_data[p] == hold_wd[p], "R11",
                            "stalled write held", wr_req_data[p], hold_wd[p]);
                        hold_w[p] = 1'b0;
                    end
                    rdy = ($urandom % 3) != 0;
                    wr_req_ready[p] = rdy;
                    if (wr_req_valid[p]) begin
                        if (rdy) begin
                            int k;
                            logic [31:0] ea;
                            logic [WW-1:0] ed;
                            k  = wr_cnt[p];
                            ea = bscale(ms[p + 2], cur_size);
                            chk(wr_req_addr[p] == ea, "R3", "write address",
                                WW'(wr_req_addr[p]), WW'(ea));
                            chk(wr_req_addr[p] < cur_size, "R4", "write address range",
                                WW'(wr_req_addr[p]), WW'(cur_size));
                            ms[p + 2] = bstep(ms[p + 2]);
                            if (k < rd_hist[0].size() && k < rd_hist[1].size()) begin
                                for (int l = 0; l < LN; l++) begin
                                    logic [31:0] a, b;
                                    a = memv(0, rd_hist[0][k], l);
                                    b = memv(1, rd_hist[1][k], l);
                                    ed[l*32 +: 32] = (p == 0) ? a + b : a * b;
                                end
                                chk(wr_req_data[p] == ed, (p == 0) ? "R1" : "R2",
                                    "R5 pair data", wr_req_data[p], ed);
                            end else begin
                                chk(1'b0, "R5", "write before its reads", WW'(k), '0);
                            end
                            wr_cnt[p]++;
                            wq_due[p].push_back(cyc + 1 + ($urandom % 3));
                        end else begin
                            hold_w[p]  = 1'b1;
                            hold_wa[p] = wr_req_addr[p];
                            hold_wd[p] = wr_req_data[p];
                        end
                    end
                    if (wq_due[p].size() > 0 && wq_due[p][0] <= cyc) begin
                        wr_rsp_valid[p] = 1'b1;
                        if (wr_rsp_ready[p]) begin
                            void'(wq_due[p].pop_front());
                            wr_rsp_n[p]++;
                        end
                    end else begin
                        wr_rsp_valid[p] = 1'b0;
                    end
                end
                if (done_exp < 0 && wr_rsp_n[0] == cur_total && wr_rsp_n[1] == cur_total)
                    done_exp = cyc + 1;
            end
        end
    end

    task automatic setup(input int sz, input int rp, input int md);
        cur_size = sz; cur_total = sz * rp; mode = md;
        done_exp = -1; done_seen = 1'b0; done_cnt = 0;
        for (int i = 0; i < 4; i++) ms[i] = (i == 0) ? 16'hACE1 : (i == 1) ? 16'h5EED
                                           : (i == 2) ? 16'hBEEF : 16'h1234;
        for (int p = 0; p < 2; p++) begin
            rq_addr[p].delete(); rq_due[p].delete(); rd_hist[p].delete(); wq_due[p].delete();
            rd_cnt[p] = 0; wr_cnt[p] = 0; wr_rsp_n[p] = 0; maxo[p] = 0;
            hold_r[p] = 1'b0; hold_w[p] = 1'b0;
        end
    endtask

    task automatic run_job(input int sz, input int rp, input int md, input bit poke);
        setup(sz, rp, md);
        @(negedge clk);
        model_on = 1'b1;
        start = 1'b1; size_w = sz; rep_w = rp;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 20000 && !done_seen; w++) begin
            @(negedge clk);
            if (poke && w == 5) begin
                start = 1'b1; size_w = 7; rep_w = 1;   // R10: ignored while running
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        model_on = 1'b0;
        chk(done_seen && done_cnt == 1, "R8", "single done pulse", WW'(done_cnt), WW'(1));
        for (int p = 0; p < 2; p++) begin
            chk(rd_cnt[p] == cur_total, "R7", "read requests", WW'(rd_cnt[p]), WW'(cur_total));
            chk(wr_cnt[p] == cur_total, poke ? "R10" : "R7", "write requests",
                WW'(wr_cnt[p]), WW'(cur_total));
            chk(maxo[p] <= MO, "R6", "outstanding reads", WW'(maxo[p]), WW'(MO));
        end
    endtask

    task automatic zero_job(input int sz, input int rp);
        @(negedge clk);
        start = 1'b1; size_w = sz; rep_w = rp;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R9", "done after zero job", WW'(done), WW'(1));
        chk(rd_req_valid == 2'b00 && wr_req_valid == 2'b00, "R9", "no traffic",
            WW'({rd_req_valid, wr_req_valid}), '0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done pulse ends", WW'(done), '0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rd_req_valid == 2'b00 && wr_req_valid == 2'b00, "R9", "still quiet",
                WW'({rd_req_valid, wr_req_valid}), '0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int szs [6] = '{1, 2, 3, 5, 17, 40};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R12", "done after reset", WW'(done), '0);
        chk(rd_req_valid == 2'b00 && wr_req_valid == 2'b00, "R12", "valids after reset",
            WW'({rd_req_valid, wr_req_valid}), '0);
        zero_job(0, 3);
        zero_job(4, 0);
        zero_job(0, 0);
        for (int md = 0; md < 2; md++)
            for (int si = 0; si < 6; si++)
                for (int rp = 1; rp <= 3; rp++)
                    run_job(szs[si], rp, md, (md == 0 && szs[si] == 17 && rp == 2));
        run_job(40, 3, 1, 1'b0);   // R3: reload at start repeats the same sequence
        report();
        $finish;
    end

endmodule